// File: doc/BRIEF.md
# Multi-block DMA channel sequencer

This block controls one DMA channel as it works through a chain of block transfers. It does not move any data. After an enable pulse it sends a one-cycle start to an external transfer engine. It then waits for that engine's block-done pulse. At the end of each block it reads the channel configuration and picks one of three outcomes: launch the next block, hold until software acknowledges, or finish the chain.

The configuration has five bits:
- a next-pointer-valid flag;
- a linked-list enable for the source side;
- a linked-list enable for the destination side;
- an auto-reload flag for the source address;
- an auto-reload flag for the destination address.

An end-of-block interrupt flag is raised when the interrupt enable is 1 and the mask bit is 0. A software clear strobe lowers the flag and releases a held channel. When a chain ends with a linked-list enable still set, the block pulses a status-fetch request for the last block before it reports completion.

Top module: `dma_chain_seq`

## Requirements
- R1: While reset is low, and at the first sample after reset, blk_start, blk_irq, stat_fetch, chan_active and chan_done are all 0.
- R2: A chan_en pulse in the idle state gives a one-cycle blk_start in the following cycle. chan_active rises in that same cycle and stays 1 until the cycle after chan_done.
- R3: blk_irq becomes 1 in the cycle after a block-done pulse accepted while irq_en=1 and irq_mask=0. A block-done accepted under any other enable/mask setting does not set it.
- R4: blk_irq holds until irq_clr is 1. An irq_clr in the same cycle as an accepted block-done that sets the flag leaves the flag set.
- R5: Reload class is cfg_reload_src=1 or cfg_reload_dst=1. If a block ends in reload class with irq_en=1, irq_mask=0 and no irq_clr, the channel parks and issues no blk_start. blk_start follows in the cycle after irq_clr is seen.
- R6: If a block ends in reload class with irq_en=0 or irq_mask=1, the next blk_start comes two cycles after the done pulse, with no stall.
- R7: Linked class is cfg_llp_valid=1, no reload, and at least one of cfg_llp_src_en or cfg_llp_dst_en set. It launches the next block two cycles after done, whatever the interrupt settings.
- R8: Terminal class is no reload with either cfg_llp_valid=0 or both linked-list enables 0. It ends the chain: with no linked-list enable, chan_done pulses for one cycle two cycles after done. chan_active is 0 one cycle later.
- R9: In terminal class with cfg_llp_src_en or cfg_llp_dst_en set, stat_fetch pulses for one cycle two cycles after done, and chan_done follows in the next cycle.
- R10: cfg_llp_valid=1 with no linked-list enable and no reload is terminal: a single block runs, with no status fetch.
- R11: A blk_done pulse while the channel is not running a block has no effect: blk_irq, chan_active and blk_start stay as they were.
- R12: The mode is taken from the configuration in the cycle after each done pulse. A reload chain repeats blocks until both reload bits read 0 at a block end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_en | input | 1 | Start pulse for a new chain (idle only) |
| cfg_llp_valid | input | 1 | Next-descriptor pointer present |
| cfg_llp_src_en | input | 1 | Source side follows linked list |
| cfg_llp_dst_en | input | 1 | Destination side follows linked list |
| cfg_reload_src | input | 1 | Source address auto-reloads between blocks |
| cfg_reload_dst | input | 1 | Destination address auto-reloads between blocks |
| irq_en | input | 1 | Channel interrupt enable |
| irq_mask | input | 1 | Block interrupt mask (1 = masked) |
| irq_clr | input | 1 | Software clear strobe for the block interrupt |
| blk_done | input | 1 | Block finished at destination, from transfer engine |
| blk_start | output | 1 | One-cycle start of a block to transfer engine |
| blk_irq | output | 1 | End-of-block interrupt flag |
| stat_fetch | output | 1 | One-cycle status-fetch request for the last block |
| chan_active | output | 1 | Channel busy with a chain |
| chan_done | output | 1 | One-cycle chain-complete pulse |

## Verification
The properties assume the transfer engine answers each blk_start with exactly one blk_done pulse, a few cycles later. They also assume the configuration bits stay still from the done pulse through the following cycle.

The bench engine follows the first rule, with a latency that cycles between 3 and 6 clocks. Configuration is changed only shortly after a block launches, so it is settled well before that block's done.

A stray done pulse is injected only while the channel is idle. That is the one departure from the engine contract, and it is made to exercise R11.

// File: rtl/dma_chain_pkg.sv
package dma_chain_pkg;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_RUN, SQ_BEND, SQ_PARK, SQ_SFETCH, SQ_FIN
  } sq_state_t;

  typedef enum logic [1:0] {
    BC_END, BC_GO, BC_HOLD
  } blk_class_t;

  typedef struct packed {
    logic nxt_valid;
    logic list_src;
    logic list_dst;
    logic rld_src;
    logic rld_dst;
  } chain_mode_t;

  // reload wins; list chaining needs a pointer and a list side; else end
  function automatic blk_class_t classify(chain_mode_t m);
    if (m.rld_src || m.rld_dst)
      return BC_HOLD;
    else if (m.nxt_valid && (m.list_src || m.list_dst))
      return BC_GO;
    else
      return BC_END;
  endfunction

  function automatic logic fetch_on_end(chain_mode_t m);
    return m.list_src | m.list_dst;
  endfunction

  function automatic logic irq_armed(logic en, logic mask);
    return en & ~mask;
  endfunction

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_chain_pkg::*;
(
  input  chain_mode_t mode,
  output blk_class_t  cls,
  output logic        want_fetch
);
  always_comb begin
    cls        = classify(mode);
    want_fetch = fetch_on_end(mode);
  end
endmodule

// File: rtl/dma_blk_irq.sv
module dma_blk_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (set_ev)
      flag <= 1'b1;
    else if (clr)
      flag <= 1'b0;
  end
endmodule

// File: rtl/dma_chain_fsm.sv
module dma_chain_fsm
  import dma_chain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en,
  input  logic       blk_done,
  input  blk_class_t cls,
  input  logic       want_fetch,
  input  logic       park_ok,
  input  logic       irq_clr,
  output sq_state_t  state,
  output logic       blk_start,
  output logic       blk_accept
);
  sq_state_t nxt;
  logic      launch;

  assign blk_accept = (state == SQ_RUN) && blk_done;

  always_comb begin
    nxt    = state;
    launch = 1'b0;
    unique case (state)
      SQ_IDLE: if (chan_en) begin nxt = SQ_RUN; launch = 1'b1; end
      SQ_RUN:  if (blk_done) nxt = SQ_BEND;
      SQ_BEND: begin
        unique case (cls)
          BC_END:  nxt = want_fetch ? SQ_SFETCH : SQ_FIN;
          BC_GO:   begin nxt = SQ_RUN; launch = 1'b1; end
          BC_HOLD: begin
            if (park_ok && !irq_clr) nxt = SQ_PARK;
            else begin nxt = SQ_RUN; launch = 1'b1; end
          end
          default: nxt = SQ_FIN;
        endcase
      end
      SQ_PARK:   if (irq_clr) begin nxt = SQ_RUN; launch = 1'b1; end
      SQ_SFETCH: nxt = SQ_FIN;
      SQ_FIN:    nxt = SQ_IDLE;
      default:   nxt = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= SQ_IDLE;
      blk_start <= 1'b0;
    end else begin
      state     <= nxt;
      blk_start <= launch;
    end
  end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
  import dma_chain_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic chan_en,
  input  logic cfg_llp_valid,
  input  logic cfg_llp_src_en,
  input  logic cfg_llp_dst_en,
  input  logic cfg_reload_src,
  input  logic cfg_reload_dst,
  input  logic irq_en,
  input  logic irq_mask,
  input  logic irq_clr,
  input  logic blk_done,
  output logic blk_start,
  output logic blk_irq,
  output logic stat_fetch,
  output logic chan_active,
  output logic chan_done
);
  chain_mode_t mode;
  blk_class_t  cls;
  sq_state_t   w_state;
  logic        want_fetch;
  logic        park_ok;
  logic        w_blk_accept;
  logic        w_irq_set;
  logic        w_parked;

  assign mode = '{nxt_valid: cfg_llp_valid, list_src: cfg_llp_src_en,
                  list_dst: cfg_llp_dst_en, rld_src: cfg_reload_src,
                  rld_dst: cfg_reload_dst};
  assign park_ok   = irq_armed(irq_en, irq_mask);
  assign w_irq_set = w_blk_accept && park_ok;
  assign w_parked  = (w_state == SQ_PARK);

  dma_mode_decode u_dec (
    .mode       (mode),
    .cls        (cls),
    .want_fetch (want_fetch)
  );

  dma_chain_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en    (chan_en),
    .blk_done   (blk_done),
    .cls        (cls),
    .want_fetch (want_fetch),
    .park_ok    (park_ok),
    .irq_clr    (irq_clr),
    .state      (w_state),
    .blk_start  (blk_start),
    .blk_accept (w_blk_accept)
  );

  dma_blk_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (w_irq_set),
    .clr    (irq_clr),
    .flag   (blk_irq)
  );

  assign stat_fetch  = (w_state == SQ_SFETCH);
  assign chan_done   = (w_state == SQ_FIN);
  assign chan_active = (w_state != SQ_IDLE);
endmodule

// File: rtl/dma_chain_chk.sv
module dma_chain_chk (
  input logic clk,
  input logic rst_n,
  input logic blk_start,
  input logic blk_irq,
  input logic irq_clr,
  input logic stat_fetch,
  input logic chan_active,
  input logic chan_done,
  input logic blk_accept,
  input logic irq_set,
  input logic parked
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |=> !blk_start); // R2
  AST_START_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_start |-> chan_active); // R2
  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> blk_irq); // R3
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_irq && !irq_clr) |=> blk_irq); // R4
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !blk_irq); // R4
  AST_PARK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && !irq_clr) |=> !blk_start); // R5
  AST_PARK_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (parked && irq_clr) |=> blk_start); // R5
  AST_FETCH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_fetch |=> chan_done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    chan_done |=> !chan_active); // R8
  AST_ACCEPT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    blk_accept |-> chan_active); // R11
endmodule

bind dma_chain_seq dma_chain_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .blk_start   (blk_start),
  .blk_irq     (blk_irq),
  .irq_clr     (irq_clr),
  .stat_fetch  (stat_fetch),
  .chan_active (chan_active),
  .chan_done   (chan_done),
  .blk_accept  (w_blk_accept),
  .irq_set     (w_irq_set),
  .parked      (w_parked)
);

// File: tb/sim_dma_chain_seq.sv
`timescale 1ns/1ps
module sim_dma_chain_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chan_en = 0, nv = 0, ls = 0, ld = 0, rs = 0, rd = 0;
  logic irq_en = 0, irq_mask = 0, irq_clr = 0;
  logic eng_done = 0, extra_done = 0;
  logic blk_done;
  logic blk_start, blk_irq, stat_fetch, chan_active, chan_done;

  int total = 0, bad = 0;
  int starts = 0, fetches = 0, dones = 0, irq_hi = 0, cyc = 0;
  bit finished = 0;

  assign blk_done = eng_done | extra_done;
  always #10 clk = ~clk;

  dma_chain_seq u0 (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .cfg_llp_valid(nv), .cfg_llp_src_en(ls), .cfg_llp_dst_en(ld),
    .cfg_reload_src(rs), .cfg_reload_dst(rd),
    .irq_en(irq_en), .irq_mask(irq_mask), .irq_clr(irq_clr),
    .blk_done(blk_done), .blk_start(blk_start), .blk_irq(blk_irq),
    .stat_fetch(stat_fetch), .chan_active(chan_active), .chan_done(chan_done)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // transfer engine: done pulse a few cycles after every start
  int cnt = 0, lat = 3;
  always @(negedge clk) begin
    eng_done = 0;
    if (!rst_n) cnt = 0;
    else begin
      if (cnt > 0) begin cnt--; if (cnt == 0) eng_done = 1; end
      if (blk_start) begin cnt = lat; starts++; lat = (lat == 6) ? 3 : lat + 1; end
      if (stat_fetch) fetches++;
      if (chan_done) dones++;
      if (blk_irq) irq_hi++;
    end
  end

  // behavioural reference: phase 0 idle,1 busy,2 judging,3 parked,4 fetch,5 closing
  int ph = 0;
  bit e_start = 0, e_irq = 0;
  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin ph = 0; e_start = 0; e_irq = 0; end
    else begin
      bit irq_now, armed, rld, lst;
      armed = irq_en && !irq_mask;
      rld = rs || rd;
      lst = ls || ld;
      irq_now = e_irq;
      if (ph == 1 && blk_done && armed) irq_now = 1;
      else if (irq_clr) irq_now = 0;
      e_start = 0;
      case (ph)
        0: if (chan_en) begin ph = 1; e_start = 1; end
        1: if (blk_done) ph = 2;
        2: begin
          if (rld) begin
            if (armed && !irq_clr) ph = 3;
            else begin ph = 1; e_start = 1; end
          end else if (nv && lst) begin ph = 1; e_start = 1; end
          else ph = lst ? 4 : 5;
        end
        3: if (irq_clr) begin ph = 1; e_start = 1; end
        4: ph = 5;
        default: ph = 0;
      endcase
      e_irq = irq_now;
    end
    #5;
    if (rst_n) begin
      chk(blk_start == e_start, "R5", "blk_start", blk_start, e_start);
      chk(blk_irq == e_irq, "R3", "blk_irq", blk_irq, e_irq);
      chk(stat_fetch == (ph == 4), "R9", "stat_fetch", stat_fetch, ph == 4);
      chk(chan_done == (ph == 5), "R8", "chan_done", chan_done, ph == 5);
      chk(chan_active == (ph != 0), "R2", "chan_active", chan_active, ph != 0);
    end
  end

  always @(posedge clk) if (cyc == 100000 && !finished) begin
    finished = 1;
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic ncyc(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic go();
    chan_en = 1; ncyc(1); chan_en = 0;
  endtask
  task automatic wait_blocks(int k);
    while (starts < k) @(negedge clk);
  endtask
  task automatic wait_idle();
    ncyc(1);
    while (chan_active) @(negedge clk);
    ncyc(1);
  endtask
  task automatic reset_counts();
    starts = 0; fetches = 0; dones = 0; irq_hi = 0;
  endtask
  task automatic pulse_clr();
    irq_clr = 1; ncyc(1); irq_clr = 0; ncyc(1);
  endtask

  initial begin
    ncyc(3);
    chk(!blk_start && !blk_irq && !stat_fetch && !chan_active && !chan_done,
        "R1", "outputs in reset", {blk_start, blk_irq, stat_fetch, chan_active, chan_done}, 0);
    rst_n = 1;
    ncyc(2);
    chk(!chan_active && !blk_irq, "R1", "outputs after reset", {chan_active, blk_irq}, 0);

    // R11: stray done while idle
    reset_counts();
    extra_done = 1; ncyc(1); extra_done = 0; ncyc(2);
    chk(!blk_irq && !chan_active && starts == 0, "R11", "stray done", {blk_irq, chan_active}, 0);

    // R7 / R9: linked chain of three blocks then terminal with fetch
    reset_counts();
    nv = 1; ls = 1; irq_en = 1; irq_mask = 0;
    go();
    chk(chan_active == 1, "R2", "active after enable", chan_active, 1);
    wait_blocks(3); nv = 0;
    wait_idle();
    chk(starts == 3, "R7", "linked blocks", starts, 3);
    chk(fetches == 1, "R9", "status fetch count", fetches, 1);
    chk(dones == 1, "R8", "done count", dones, 1);
    chk(blk_irq == 1, "R4", "irq held without clear", blk_irq, 1);
    pulse_clr();
    chk(blk_irq == 0, "R4", "irq after clear", blk_irq, 0);
    ls = 0;

    // R5 / R12: reload with irq armed parks between blocks
    reset_counts();
    rs = 1;
    go();
    ncyc(14);
    chk(starts == 1, "R5", "parked, no second start", starts, 1);
    pulse_clr();
    wait_blocks(2); rs = 0;
    wait_idle();
    chk(starts == 2, "R12", "reload blocks", starts, 2);
    chk(fetches == 0, "R8", "no fetch in plain end", fetches, 0);
    chk(blk_irq == 1, "R3", "irq from last block", blk_irq, 1);
    pulse_clr();

    // R6 / R12: reload with mask set runs without stall
    reset_counts();
    rd = 1; irq_mask = 1;
    go();
    wait_blocks(4); rd = 0;
    wait_idle();
    chk(starts == 4, "R6", "masked reload blocks", starts, 4);
    chk(irq_hi == 0, "R3", "masked irq never set", irq_hi, 0);

    // R10: pointer valid with no list side and no reload
    reset_counts();
    irq_mask = 0; irq_en = 0; nv = 1;
    go();
    wait_idle();
    chk(starts == 1 && fetches == 0, "R10", "single block, no fetch", starts * 10 + fetches, 10);
    nv = 0;

    // R4: clear held high, set wins and chain does not park
    reset_counts();
    irq_en = 1; rs = 1; irq_clr = 1;
    go();
    wait_blocks(3); rs = 0;
    wait_idle();
    chk(starts == 3, "R4", "no park with clear held", starts, 3);
    chk(irq_hi > 0, "R4", "set wins over clear", irq_hi > 0, 1);
    irq_clr = 0; ncyc(2);
    chk(blk_irq == 0, "R4", "irq low after clear", blk_irq, 0);

    ncyc(4);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule